// File: doc/BRIEF.md
# ADC Conversion Sequencer Controller

This controller sits in front of an analog-to-digital converter. It starts a conversion sequence on a software start strobe, or on a rising edge of one of several hardware trigger inputs. The software then makes no further request: the controller converts every active channel in turn, one conversion at a time, and returns to idle. Each finished conversion leaves the block as a one-cycle result strobe that carries the sample and the channel it belongs to.

The conversion order has two modes. In the default mode the enabled channels are converted in ascending index order. In user-order mode a list of programmed slots sets the order: each slot holds a channel number and its own enable bit, so channels may be reordered or repeated. In sleep mode the converter is kept powered down between sequences. An accepted trigger powers it up and waits a programmable startup count before the first conversion. The controller powers the converter down again after the last result.

The controller accepts a trigger only while it is idle. The configuration is captured when the trigger is accepted, and a trigger that arrives during a sequence is dropped.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A one-cycle `sw_start_i` pulse, sampled while idle, starts a sequence, and `busy_o` is high in the following cycle.
- R2: A rising edge on `hw_trig_i[trig_sel_i]` starts a sequence only when `trig_en_i` is 1. The edge takes effect within a few cycles after a two-stage synchronizer. Edges on unselected inputs, and all edges while `trig_en_i` is 0, start nothing.
- R3: With `user_seq_en_i` = 0, the channels whose `ch_en_i` bit is set are converted once each, in ascending index order.
- R4: With `user_seq_en_i` = 1, slots 0 to 7 are visited in ascending order. Slot k holds the channel `slot_ch_i[3k+2:3k]` and is converted only if `slot_en_i[k]` is 1. A channel may appear in several slots.
- R5: Each `adc_done_i` answering a conversion gives exactly one `res_valid_o` pulse in the next cycle. That pulse carries `adc_data_i` on `res_data_o` and the converted channel on `res_ch_o`.
- R6: `adc_start_o` is a one-cycle pulse. No new start is issued until the previous conversion has returned `adc_done_i`.
- R7: A software or hardware trigger that arrives while a sequence is running is ignored: it is not queued and it adds no conversions.
- R8: With `sleep_en_i` = 1, `adc_pwr_o` is low while idle. It rises when a trigger is accepted. The first `adc_start_o` comes exactly `startup_cycles_i` + 1 cycles after that rise, and `adc_pwr_o` is low again once the sequence ends.
- R9: With `sleep_en_i` = 0, `adc_pwr_o` stays high, and the first `adc_start_o` comes in the cycle after acceptance.
- R10: A trigger with no channel or slot enabled (in the active mode) produces no result, and `busy_o` does not rise.
- R11: After reset `busy_o`, `res_valid_o` and `adc_start_o` are low. `busy_o` stays high from acceptance through the cycle of the last `res_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_start_i | input | 1 | Software start strobe |
| hw_trig_i | input | NUM_HW_TRIG | Asynchronous hardware trigger sources |
| trig_sel_i | input | TSEL_W | Index of the hardware trigger source |
| trig_en_i | input | 1 | Enables hardware triggering |
| sleep_en_i | input | 1 | Power the converter only during sequences |
| user_seq_en_i | input | 1 | Use the programmed slot order |
| ch_en_i | input | NUM_CH | Channel enable mask |
| slot_ch_i | input | NUM_SLOTS*CH_W | Channel number per slot, slot k at [k*CH_W +: CH_W] |
| slot_en_i | input | NUM_SLOTS | Slot enable mask |
| startup_cycles_i | input | STARTUP_W | Converter startup wait in cycles |
| adc_pwr_o | output | 1 | Converter power enable |
| adc_start_o | output | 1 | Start one conversion |
| adc_ch_o | output | CH_W | Channel to convert |
| adc_done_i | input | 1 | Conversion complete |
| adc_data_i | input | DATA_W | Converted sample |
| res_valid_o | output | 1 | Result strobe |
| res_data_o | output | DATA_W | Result sample |
| res_ch_o | output | CH_W | Result channel |
| busy_o | output | 1 | Sequence in progress |

## Verification
A corrupted remaining-position mask shows up within one sequence: a conversion is lost, added or out of order, and the comparison of the result channel list fails on the first wrong strobe. A stuck state or a lost done shows as `busy_o` that never falls, which the bench's per-sequence timeout catches within a few thousand cycles. A wrong startup count is caught by timing the first start against the power rise, and a reopened trigger window is caught by the result count when triggers are hammered during a long sequence.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAKE  = 2'd1,
    ST_ISSUE = 2'd2,
    ST_WAIT  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
  parameter int unsigned N_SRC  = 4,
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] trig_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             rise_o
);
  logic [N_SRC-1:0] sync_q [STAGES];
  logic             sel_lvl;
  logic             prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) sync_q[s] <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q[0] <= trig_i;
      for (int s = 1; s < STAGES; s++) sync_q[s] <= sync_q[s-1];
      prev_q <= sel_lvl;
    end
  end

  always_comb begin
    sel_lvl = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (sel_i == SEL_W'(i)) sel_lvl = sync_q[STAGES-1][i];
    end
  end

  assign rise_o = sel_lvl & ~prev_q;
endmodule

// File: rtl/adc_first_set.sv
module adc_first_set #(
  parameter int unsigned W     = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic [W-1:0]     mask_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |mask_i;
endmodule

// File: rtl/adc_startup_timer.sv
module adc_startup_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - W'(1);
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned NUM_CH      = 8,
  parameter int unsigned NUM_SLOTS   = 8,
  parameter int unsigned NUM_HW_TRIG = 4,
  parameter int unsigned STARTUP_W   = 8,
  parameter int unsigned DATA_W      = 12,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  parameter int unsigned TSEL_W      = (NUM_HW_TRIG > 1) ? $clog2(NUM_HW_TRIG) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        sw_start_i,
  input  logic [NUM_HW_TRIG-1:0]      hw_trig_i,
  input  logic [TSEL_W-1:0]           trig_sel_i,
  input  logic                        trig_en_i,
  input  logic                        sleep_en_i,
  input  logic                        user_seq_en_i,
  input  logic [NUM_CH-1:0]           ch_en_i,
  input  logic [NUM_SLOTS*CH_W-1:0]   slot_ch_i,
  input  logic [NUM_SLOTS-1:0]        slot_en_i,
  input  logic [STARTUP_W-1:0]        startup_cycles_i,
  output logic                        adc_pwr_o,
  output logic                        adc_start_o,
  output logic [CH_W-1:0]             adc_ch_o,
  input  logic                        adc_done_i,
  input  logic [DATA_W-1:0]           adc_data_i,
  output logic                        res_valid_o,
  output logic [DATA_W-1:0]           res_data_o,
  output logic [CH_W-1:0]             res_ch_o,
  output logic                        busy_o
);
  localparam int unsigned POS_N = (NUM_CH > NUM_SLOTS) ? NUM_CH : NUM_SLOTS;
  localparam int unsigned POS_W = (POS_N > 1) ? $clog2(POS_N) : 1;

  seq_state_e        state_q;
  logic [POS_N-1:0]  rem_q;
  logic [CH_W-1:0]   pos_ch_q [POS_N];
  logic [POS_N-1:0]  pos_en_d;
  logic [CH_W-1:0]   pos_ch_d [POS_N];
  logic [POS_W-1:0]  pick_idx;
  logic              pick_any;
  logic [POS_N-1:0]  rem_clr;
  logic              hw_rise;
  logic              trig_fire;
  logic              accept;
  logic              wake_done;
  logic              res_valid_q;
  logic [DATA_W-1:0] res_data_q;
  logic [CH_W-1:0]   res_ch_q;

  // Per-position enable and channel for both ordering modes
  for (genvar p = 0; p < POS_N; p++) begin : g_pos
    logic            norm_en, user_en;
    logic [CH_W-1:0] norm_ch, user_ch;
    if (p < NUM_CH) begin : g_norm
      assign norm_en = ch_en_i[p];
      assign norm_ch = CH_W'(p);
    end else begin : g_norm_none
      assign norm_en = 1'b0;
      assign norm_ch = '0;
    end
    if (p < NUM_SLOTS) begin : g_user
      assign user_en = slot_en_i[p];
      assign user_ch = slot_ch_i[p*CH_W +: CH_W];
    end else begin : g_user_none
      assign user_en = 1'b0;
      assign user_ch = '0;
    end
    assign pos_en_d[p] = user_seq_en_i ? user_en : norm_en;
    assign pos_ch_d[p] = user_seq_en_i ? user_ch : norm_ch;
  end

  adc_trig_sync #(
    .N_SRC (NUM_HW_TRIG),
    .SEL_W (TSEL_W),
    .STAGES(SYNC_STAGES)
  ) u_trig_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .trig_i(hw_trig_i),
    .sel_i (trig_sel_i),
    .rise_o(hw_rise)
  );

  adc_first_set #(
    .W    (POS_N),
    .IDX_W(POS_W)
  ) u_pick (
    .mask_i(rem_q),
    .idx_o (pick_idx),
    .any_o (pick_any)
  );

  adc_startup_timer #(
    .W(STARTUP_W)
  ) u_startup (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept),
    .val_i    (startup_cycles_i),
    .expired_o(wake_done)
  );

  assign trig_fire = sw_start_i | (trig_en_i & hw_rise);
  assign accept    = (state_q == ST_IDLE) & trig_fire;
  assign rem_clr   = rem_q & ~(POS_N'(1) << pick_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      for (int p = 0; p < POS_N; p++) pos_ch_q[p] <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (trig_fire) begin
            rem_q <= pos_en_d;
            for (int p = 0; p < POS_N; p++) pos_ch_q[p] <= pos_ch_d[p];
            if (|pos_en_d) state_q <= sleep_en_i ? ST_WAKE : ST_ISSUE;
          end
        end
        ST_WAKE:  if (wake_done) state_q <= ST_ISSUE;
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (adc_done_i) begin
            rem_q   <= rem_clr;
            state_q <= (rem_clr == '0) ? ST_IDLE : ST_ISSUE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_q <= 1'b0;
      res_data_q  <= '0;
      res_ch_q    <= '0;
    end else begin
      res_valid_q <= (state_q == ST_WAIT) & adc_done_i;
      if ((state_q == ST_WAIT) & adc_done_i) begin
        res_data_q <= adc_data_i;
        res_ch_q   <= adc_ch_o;
      end
    end
  end

  assign adc_ch_o    = pick_any ? pos_ch_q[pick_idx] : '0;
  assign adc_start_o = (state_q == ST_ISSUE);
  assign adc_pwr_o   = (state_q == ST_IDLE) ? ~sleep_en_i : 1'b1;
  assign busy_o      = (state_q != ST_IDLE) | res_valid_q;
  assign res_valid_o = res_valid_q;
  assign res_data_o  = res_data_q;
  assign res_ch_o    = res_ch_q;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int unsigned CH_W = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            adc_pwr_o,
  input logic            adc_start_o,
  input logic [CH_W-1:0] adc_ch_o,
  input logic            adc_done_i,
  input logic            res_valid_o,
  input logic [CH_W-1:0] res_ch_o,
  input logic            busy_o
);
  logic            outstanding_q;
  logic [CH_W-1:0] last_ch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      outstanding_q <= 1'b0;
      last_ch_q     <= '0;
    end else begin
      if (adc_start_o) begin
        outstanding_q <= 1'b1;
        last_ch_q     <= adc_ch_o;
      end else if (adc_done_i) begin
        outstanding_q <= 1'b0;
      end
    end
  end

  assert_start_powered_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |-> adc_pwr_o);

  assert_start_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |=> !adc_start_o);

  assert_one_outstanding_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |-> !outstanding_q);

  assert_valid_after_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $past(adc_done_i));

  assert_valid_channel_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (res_ch_o == last_ch_q));

  assert_busy_until_result_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(res_valid_o));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.CH_W(CH_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .adc_pwr_o  (adc_pwr_o),
  .adc_start_o(adc_start_o),
  .adc_ch_o   (adc_ch_o),
  .adc_done_i (adc_done_i),
  .res_valid_o(res_valid_o),
  .res_ch_o   (res_ch_o),
  .busy_o     (busy_o)
);

// File: tb/adc_seq_ctrl_tb.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb;
  localparam int NCH = 8, NSL = 8, NHW = 4, CHW = 3, TSW = 2, SUW = 8, DW = 12;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           sw_start_i = 1'b0;
  logic [NHW-1:0] hw_trig_i = '0;
  logic [TSW-1:0] trig_sel_i = '0;
  logic           trig_en_i = 1'b0;
  logic           sleep_en_i = 1'b0;
  logic           user_seq_en_i = 1'b0;
  logic [NCH-1:0] ch_en_i = '0;
  logic [NSL*CHW-1:0] slot_ch_i = '0;
  logic [NSL-1:0] slot_en_i = '0;
  logic [SUW-1:0] startup_cycles_i = '0;
  logic           adc_pwr_o, adc_start_o, res_valid_o, busy_o;
  logic [CHW-1:0] adc_ch_o, res_ch_o;
  logic           adc_done_i = 1'b0;
  logic [DW-1:0]  adc_data_i = '0;
  logic [DW-1:0]  res_data_o;

  always #2 clk_i = ~clk_i;

  adc_seq_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sw_start_i(sw_start_i), .hw_trig_i(hw_trig_i),
    .trig_sel_i(trig_sel_i), .trig_en_i(trig_en_i), .sleep_en_i(sleep_en_i),
    .user_seq_en_i(user_seq_en_i), .ch_en_i(ch_en_i), .slot_ch_i(slot_ch_i),
    .slot_en_i(slot_en_i), .startup_cycles_i(startup_cycles_i), .adc_pwr_o(adc_pwr_o),
    .adc_start_o(adc_start_o), .adc_ch_o(adc_ch_o), .adc_done_i(adc_done_i),
    .adc_data_i(adc_data_i), .res_valid_o(res_valid_o), .res_data_o(res_data_o),
    .res_ch_o(res_ch_o), .busy_o(busy_o)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int conv_lat = 1;
  int dly = 0;
  bit pend = 0;
  logic [CHW-1:0] conv_ch = '0;
  int conv_k = 0;
  int n_res = 0, n_start = 0;
  int got_ch [16];
  int got_data [16];
  int exp_ch [16];
  int exp_n = 0;
  bit busy_seen = 0;
  bit prev_pwr = 0;
  int pwr_rise_cyc = 0;
  bit gap_pend = 0;
  int gap = -1;

  always @(posedge clk_i) cyc <= cyc + 1;

  // Converter model and output monitor, both on the falling edge
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      adc_done_i <= 1'b0;
      pend = 0;
    end else begin
      adc_done_i <= 1'b0;
      if (pend) begin
        if (dly == 0) begin
          adc_done_i <= 1'b1;
          adc_data_i <= DW'(conv_k * 16 + int'(conv_ch));
          conv_k = conv_k + 1;
          pend = 0;
        end else dly = dly - 1;
      end
      if (adc_start_o) begin
        pend = 1;
        dly = conv_lat;
        conv_ch = adc_ch_o;
        n_start = n_start + 1;
        if (gap_pend) begin
          gap = cyc - pwr_rise_cyc;
          gap_pend = 0;
        end
      end
      if (res_valid_o && n_res < 16) begin
        got_ch[n_res] = int'(res_ch_o);
        got_data[n_res] = int'(res_data_o);
        n_res = n_res + 1;
      end
      if (busy_o) busy_seen = 1;
      if (adc_pwr_o && !prev_pwr) begin
        pwr_rise_cyc = cyc;
        gap_pend = 1;
      end
      prev_pwr = adc_pwr_o;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) begin
      @(posedge clk_i);
      #1;
    end
  endtask

  function automatic void compute_expected();
    exp_n = 0;
    for (int p = 0; p < 8; p++) begin
      if (user_seq_en_i) begin
        if (slot_en_i[p]) begin
          exp_ch[exp_n] = int'(slot_ch_i[p*CHW +: CHW]);
          exp_n++;
        end
      end else if (ch_en_i[p]) begin
        exp_ch[exp_n] = p;
        exp_n++;
      end
    end
  endfunction

  task automatic clear_capture();
    n_res = 0; n_start = 0; conv_k = 0; busy_seen = 0; gap = -1; gap_pend = 0;
    prev_pwr = adc_pwr_o;
  endtask

  task automatic wait_idle(input string tag);
    int t;
    t = 0;
    while (!(busy_seen && !busy_o) && t < 3000) begin
      step();
      t++;
    end
    check(t < 3000, tag, t, 3000);
  endtask

  task automatic fire_sw();
    sw_start_i = 1'b1;
    step();
    sw_start_i = 1'b0;
  endtask

  task automatic fire_hw(input int src);
    hw_trig_i[src] = 1'b1;
    step(4);
    hw_trig_i = '0;
  endtask

  task automatic compare(input string tag);
    check(n_res == exp_n, {tag, " result count"}, n_res, exp_n);
    for (int k = 0; k < exp_n && k < n_res; k++) begin
      check(got_ch[k] == exp_ch[k], {tag, " channel order"}, got_ch[k], exp_ch[k]);
      check(got_data[k] == k * 16 + exp_ch[k], "R5 data", got_data[k], k * 16 + exp_ch[k]);
    end
  endtask

  // One full sequence with checks; kind 0 software, 1 hardware
  task automatic run_one(input int kind);
    string mtag;
    mtag = user_seq_en_i ? "R4" : "R3";
    compute_expected();
    clear_capture();
    if (kind == 0) fire_sw();
    else begin
      trig_en_i = 1'b1;
      fire_hw(int'(trig_sel_i));
    end
    if (exp_n == 0) begin
      step(20);
      check(!busy_seen, "R10 busy on empty", int'(busy_seen), 0);
      check(n_res == 0, "R10 results on empty", n_res, 0);
    end else begin
      wait_idle({mtag, " sequence end"});
      step(3);
      compare(mtag);
      if (sleep_en_i) begin
        check(gap == int'(startup_cycles_i) + 1, "R8 startup gap", gap, int'(startup_cycles_i) + 1);
        check(adc_pwr_o == 1'b0, "R8 power down", int'(adc_pwr_o), 0);
      end else begin
        check(adc_pwr_o == 1'b1, "R9 power held", int'(adc_pwr_o), 1);
      end
    end
    trig_en_i = 1'b0;
    step(4);
  endtask

  initial begin : watchdog
    wait (cyc > 150000);
    n_fail++;
    n_chk++;
    $display("FAIL R11 watchdog act=%0d exp=%0d", cyc, 150000);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h00c0ffee));
    step(3);
    rst_ni = 1'b1;
    step();
    check(!busy_o && !res_valid_o && !adc_start_o, "R11 reset state",
          int'({busy_o, res_valid_o, adc_start_o}), 0);

    // R1/R9: start visible the cycle after the strobe
    ch_en_i = 8'h01; conv_lat = 2;
    compute_expected(); clear_capture();
    sw_start_i = 1'b1;
    step();
    check(busy_o == 1'b1, "R1 busy after strobe", int'(busy_o), 1);
    check(adc_start_o == 1'b1, "R9 immediate start", int'(adc_start_o), 1);
    sw_start_i = 1'b0;
    wait_idle("R1 end");
    step(2);
    compare("R3");

    // R7: triggers during a running sequence
    ch_en_i = 8'hFF; conv_lat = 3; trig_en_i = 1'b1; trig_sel_i = 2'd1;
    compute_expected(); clear_capture();
    fire_sw();
    step(1);
    fire_sw();
    hw_trig_i[1] = 1'b1;
    step(3);
    hw_trig_i = '0;
    step(4);
    fire_sw();
    wait_idle("R7 end");
    step(10);
    check(n_res == 8, "R7 no extra conversions", n_res, 8);
    check(busy_o == 1'b0, "R7 no queued sequence", int'(busy_o), 0);
    trig_en_i = 1'b0;
    step(4);

    // R2: disabled hardware trigger and unselected source
    ch_en_i = 8'h0A; trig_sel_i = 2'd2; trig_en_i = 1'b0;
    clear_capture();
    fire_hw(2);
    step(15);
    check(!busy_seen, "R2 disabled trigger ignored", int'(busy_seen), 0);
    trig_en_i = 1'b1;
    clear_capture();
    fire_hw(1);
    step(15);
    check(!busy_seen, "R2 unselected source ignored", int'(busy_seen), 0);
    trig_en_i = 1'b0;
    run_one(1);

    // R10: nothing enabled, both modes
    ch_en_i = '0; user_seq_en_i = 1'b0;
    run_one(0);
    user_seq_en_i = 1'b1; slot_en_i = '0; ch_en_i = 8'hFF;
    run_one(0);

    // R4: repeated and reordered channels with gaps
    slot_ch_i = {3'd7, 3'd0, 3'd5, 3'd5, 3'd2, 3'd7, 3'd5, 3'd7};
    slot_en_i = 8'b1011_0111;
    ch_en_i = 8'h01;
    run_one(0);

    // R8: sleep mode with zero and long startup
    sleep_en_i = 1'b1; user_seq_en_i = 1'b0; ch_en_i = 8'h81;
    step(2);
    check(adc_pwr_o == 1'b0, "R8 idle powered down", int'(adc_pwr_o), 0);
    startup_cycles_i = 8'd0;
    run_one(0);
    startup_cycles_i = 8'd10;
    run_one(1);
    sleep_en_i = 1'b0;

    // Randomised configurations
    for (int it = 0; it < 60; it++) begin
      ch_en_i = NCH'($urandom);
      slot_en_i = NSL'($urandom);
      slot_ch_i = (NSL*CHW)'($urandom);
      user_seq_en_i = 1'($urandom);
      sleep_en_i = 1'($urandom);
      startup_cycles_i = SUW'($urandom % 12);
      conv_lat = int'($urandom % 4);
      trig_sel_i = TSW'($urandom);
      if (($urandom % 8) == 0) begin
        if (user_seq_en_i) slot_en_i = '0; else ch_en_i = '0;
      end
      step(2);
      run_one(int'($urandom % 2));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule